// File: doc/BRIEF.md
# First-Come Request Arbiter

This block shares one resource among four requesters and serves them strictly in the order their requests arrived. Each clock cycle in which a request line is high counts as one request from that port. Every request carries a hold length of one to ten cycles, sampled in the same cycle as the request line. The request becomes an entry, made of the port number and the length, in an internal queue. The head of the queue is turned into a one-hot grant that stays high for exactly that many cycles. When the grant ends, the next queued grant follows with no idle cycle in between.

The block has no reset pin. All state takes a declared power-up value: queue empty, no grant active and the overflow flag clear. The request inputs are plain level signals and have no ready path, so there is no back-pressure. A request that finds no free queue entry is discarded, and a sticky overflow output records that this happened. A requester that must not lose a request has to limit its own outstanding count. The flag stays set until the next power-up.

Top module: `fcfs_arbiter`

## Requirements
- R1: At power-up, before any request, the grant vector is all zero and the overflow flag is low.
- R2: A request line high for one cycle yields exactly one grant to that port. A line held high for N cycles yields N separate grants, each with the length sampled in its own cycle.
- R3: Requests from different cycles are granted in the order of their cycles, regardless of port number.
- R4: Requests raised in the same cycle are queued in ascending port order, so port 0 comes first.
- R5: A grant stays high for the sampled length field, which is 4 bits per port with port p at bits [4p+3:4p]. A value of 0 gives 1 cycle, values 1 to 10 give that many cycles, and values 11 to 15 give 10 cycles.
- R6: At most one grant bit is high in any cycle. Grant bit p belongs to request line p.
- R7: A request sampled at a clock edge while the block is idle gets its grant from the following edge. When one grant ends and the queue holds an entry, the next grant starts in the very next cycle.
- R8: The queue holds 16 entries. Requests that find no free entry are dropped, higher port numbers first within a cycle, and the overflow flag then rises and stays high. Free space is counted before that edge's pop.
- R9: A port may request again while a grant is active, including its own grant, and the new request is queued behind the entries already waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all state changes on the rising edge |
| req_i | input | 4 | Request lines, bit p for port p; each high cycle is one request |
| req_len_i | input | 16 | Grant length per port, 4 bits each, sampled with the request |
| gnt_o | output | 4 | One-hot grant, bit p for port p, all zero when idle |
| ovf_o | output | 1 | Sticky flag set when a request was dropped on a full queue |

## Verification
The bench builds the arbiter with its default values: four ports, 4-bit lengths capped at 10 and a 16-entry queue. With these values a burst of all four ports held for five cycles at the longest length fills the queue in the fifth cycle while the first grant is still running. That exercises the drop order and the overflow flag. Smaller patterns check the cycle-exact grant stream against an order rebuilt from the stimulus. These include mixed arrival orders, same-cycle ties, held request lines, clamped lengths and re-requests during an active grant.

// File: rtl/fcarb_pkg.sv
package fcarb_pkg;

  localparam int DFLT_PORTS   = 4;
  localparam int DFLT_LEN_W   = 4;
  localparam int DFLT_MAX_LEN = 10;
  localparam int DFLT_DEPTH   = 16;

endpackage

// File: rtl/fcarb_capture.sv
module fcarb_capture #(
  parameter int NP      = 4,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 10,
  localparam int IDX_W  = $clog2(NP),
  localparam int RANK_W = $clog2(NP + 1),
  localparam int ENT_W  = IDX_W + LEN_W
) (
  input  logic [NP-1:0]        req_i,
  input  logic [NP*LEN_W-1:0]  req_len_i,
  output logic [NP*RANK_W-1:0] rank_o,
  output logic [NP*ENT_W-1:0]  ent_o,
  output logic [RANK_W-1:0]    n_req_o
);

  // Slot of each request in this cycle's batch: lower port numbers come first.
  always_comb begin
    logic [RANK_W-1:0] run;
    run = '0;
    for (int p = 0; p < NP; p++) begin
      rank_o[p*RANK_W +: RANK_W] = run;
      run = run + RANK_W'(req_i[p]);
    end
    n_req_o = run;
  end

  // One entry per port: port number plus length forced into 1..MAX_LEN.
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [LEN_W-1:0] raw;
    logic [LEN_W-1:0] held;
    assign raw = req_len_i[p*LEN_W +: LEN_W];
    always_comb begin
      if (raw == '0)
        held = LEN_W'(1);
      else if (raw > LEN_W'(MAX_LEN))
        held = LEN_W'(MAX_LEN);
      else
        held = raw;
    end
    assign ent_o[p*ENT_W +: ENT_W] = {IDX_W'(p), held};
  end

endmodule

// File: rtl/fcarb_queue.sv
module fcarb_queue #(
  parameter int NP      = 4,
  parameter int LEN_W   = 4,
  parameter int DEPTH   = 16,
  localparam int IDX_W  = $clog2(NP),
  localparam int RANK_W = $clog2(NP + 1),
  localparam int ENT_W  = IDX_W + LEN_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic [NP-1:0]        in_valid_i,
  input  logic [NP*RANK_W-1:0] in_rank_i,
  input  logic [NP*ENT_W-1:0]  in_ent_i,
  input  logic [RANK_W-1:0]    n_req_i,
  input  logic                 pop_i,
  output logic [ENT_W-1:0]     head_o,
  output logic                 have_o,
  output logic                 drop_o
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr = '0;
  logic [AW-1:0]    rd_ptr = '0;
  logic [CNT_W-1:0] count  = '0;
  logic             armed  = 1'b0;

  logic [CNT_W-1:0] space;
  logic [CNT_W-1:0] wanted;
  logic [CNT_W-1:0] taken;

  // Free space is judged before this edge's pop.
  assign space  = CNT_W'(DEPTH) - count;
  assign wanted = CNT_W'(n_req_i);
  assign taken  = (wanted > space) ? space : wanted;
  assign drop_o = (wanted > space);
  assign head_o = mem[rd_ptr];
  assign have_o = (count != '0);

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (in_valid_i[p] && (CNT_W'(in_rank_i[p*RANK_W +: RANK_W]) < space))
        mem[wr_ptr + AW'(in_rank_i[p*RANK_W +: RANK_W])] <= in_ent_i[p*ENT_W +: ENT_W];
    end
    wr_ptr <= wr_ptr + AW'(taken);
    rd_ptr <= rd_ptr + AW'(pop_i);
    count  <= count + taken - CNT_W'(pop_i);
  end

  always_ff @(posedge clk) armed <= 1'b1;

  // R8: occupancy never passes the queue depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!armed)
    count <= CNT_W'(DEPTH));

  // R7: a grant is only started from a waiting entry
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!armed)
    pop_i |-> (count != '0));

  // R8: a full queue with no pop cannot grow
  p_full_holds_r8: assert property (@(posedge clk) disable iff (!armed)
    (count == CNT_W'(DEPTH) && !pop_i) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/fcarb_grant.sv
module fcarb_grant #(
  parameter int NP      = 4,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 10,
  localparam int IDX_W  = $clog2(NP),
  localparam int ENT_W  = IDX_W + LEN_W
) (
  input  logic             clk,
  input  logic             have_i,
  input  logic [ENT_W-1:0] head_i,
  output logic             pop_o,
  output logic [NP-1:0]    gnt_o
);

  logic             active  = 1'b0;
  logic [IDX_W-1:0] cur_idx = '0;
  logic [LEN_W-1:0] rem     = '0;
  logic             armed   = 1'b0;
  logic             last;

  assign last  = active && (rem == LEN_W'(1));
  assign pop_o = have_i && (!active || last);
  assign gnt_o = active ? ({{(NP-1){1'b0}}, 1'b1} << cur_idx) : '0;

  always_ff @(posedge clk) begin
    if (pop_o) begin
      active  <= 1'b1;
      cur_idx <= head_i[ENT_W-1 -: IDX_W];
      rem     <= head_i[LEN_W-1:0];
    end else if (last) begin
      active <= 1'b0;
    end else if (active) begin
      rem <= rem - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) armed <= 1'b1;

  // R6: never more than one grant bit
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!armed)
    $onehot0(gnt_o));

  // R5: remaining length of a live grant stays in the legal range
  p_len_range_r5: assert property (@(posedge clk) disable iff (!armed)
    active |-> (rem >= LEN_W'(1) && rem <= LEN_W'(MAX_LEN)));

  // R5: the owner does not change in the middle of a grant
  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!armed)
    (active && rem > LEN_W'(1)) |=> (active && $stable(gnt_o)));

  // R7: an idle arbiter with a waiting entry grants on the next edge
  p_start_r7: assert property (@(posedge clk) disable iff (!armed)
    (!active && have_i) |=> (gnt_o != '0));

  // R7: no idle cycle between grants while entries wait
  p_no_gap_r7: assert property (@(posedge clk) disable iff (!armed)
    (last && have_i) |=> (gnt_o != '0));

endmodule

// File: rtl/fcfs_arbiter.sv
module fcfs_arbiter
  import fcarb_pkg::*;
#(
  parameter int NP      = DFLT_PORTS,
  parameter int LEN_W   = DFLT_LEN_W,
  parameter int MAX_LEN = DFLT_MAX_LEN,
  parameter int DEPTH   = DFLT_DEPTH,
  localparam int IDX_W  = $clog2(NP),
  localparam int RANK_W = $clog2(NP + 1),
  localparam int ENT_W  = IDX_W + LEN_W
) (
  input  logic                clk,
  input  logic [NP-1:0]       req_i,
  input  logic [NP*LEN_W-1:0] req_len_i,
  output logic [NP-1:0]       gnt_o,
  output logic                ovf_o
);

  logic [NP*RANK_W-1:0] rank;
  logic [NP*ENT_W-1:0]  ents;
  logic [RANK_W-1:0]    n_req;
  logic [ENT_W-1:0]     head;
  logic                 have;
  logic                 pop;
  logic                 drop;
  logic                 ovf_q = 1'b0;
  logic                 armed = 1'b0;

  fcarb_capture #(.NP(NP), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_capture (
    .req_i     (req_i),
    .req_len_i (req_len_i),
    .rank_o    (rank),
    .ent_o     (ents),
    .n_req_o   (n_req)
  );

  fcarb_queue #(.NP(NP), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .in_valid_i (req_i),
    .in_rank_i  (rank),
    .in_ent_i   (ents),
    .n_req_i    (n_req),
    .pop_i      (pop),
    .head_o     (head),
    .have_o     (have),
    .drop_o     (drop)
  );

  fcarb_grant #(.NP(NP), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_grant (
    .clk    (clk),
    .have_i (have),
    .head_i (head),
    .pop_o  (pop),
    .gnt_o  (gnt_o)
  );

  always_ff @(posedge clk) begin
    if (drop) ovf_q <= 1'b1;
  end
  assign ovf_o = ovf_q;

  always_ff @(posedge clk) armed <= 1'b1;

  // R8: the overflow flag never clears once set
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!armed)
    ovf_o |=> ovf_o);

  // R8: the flag only rises after a cycle with requests
  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!armed)
    $rose(ovf_o) |-> ($past(req_i) != '0));

endmodule

// File: tb/fcfs_arbiter_tb_top.sv
module fcfs_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int LW         = 4;

  logic             clk = 1'b0;
  logic [NP-1:0]    req = '0;
  logic [NP*LW-1:0] req_len = '0;
  logic [NP-1:0]    gnt;
  logic             ovf;

  int n_checks = 0;
  int n_fail   = 0;

  // stimulus per cycle and expected / actual grant streams
  logic [NP-1:0]    s_req [64];
  logic [NP*LW-1:0] s_len [64];
  int               e_str [512];
  int               a_str [512];
  int               e_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcfs_arbiter dut_i (
    .clk       (clk),
    .req_i     (req),
    .req_len_i (req_len),
    .gnt_o     (gnt),
    .ovf_o     (ovf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp(input int v);
    if (v == 0) return 1;
    if (v > 10) return 10;
    return v;
  endfunction

  // Expected stream: one idle sample, then each accepted request in cycle
  // order, ascending port within a cycle, held for its clamped length.
  task automatic build_expect(input int ncyc, input int limit);
    int pos = 1;
    int taken = 0;
    e_str[0] = 0;
    for (int c = 0; c < ncyc; c++) begin
      for (int p = 0; p < NP; p++) begin
        if (s_req[c][p] && taken < limit) begin
          taken++;
          for (int k = 0; k < clamp(int'(s_len[c][p*LW +: LW])); k++) begin
            e_str[pos] = 1 << p;
            pos++;
          end
        end
      end
    end
    for (int k = 0; k < 3; k++) begin
      e_str[pos] = 0;
      pos++;
    end
    e_len = pos;
  endtask

  task automatic run_case(input string tag, input int ncyc, input int limit);
    int bad_at = -1;
    int multi = 0;
    build_expect(ncyc, limit);
    for (int c = 0; c <= e_len; c++) begin
      @(negedge clk);
      if (c > 0) a_str[c-1] = int'(gnt);
      if (c < ncyc) begin
        req = s_req[c];
        req_len = s_len[c];
      end else begin
        req = '0;
        req_len = '0;
      end
    end
    for (int i = 0; i < e_len; i++) begin
      if (bad_at < 0 && a_str[i] != e_str[i]) bad_at = i;
      if ($countones(a_str[i]) > 1) multi++;
    end
    if (bad_at >= 0)
      check(1'b0, {tag, " grant stream"}, a_str[bad_at], e_str[bad_at]);
    else
      check(1'b1, tag, 0, 0);
    check(multi == 0, {tag, " R6 one-hot"}, multi, 0);
  endtask

  task automatic clear_stim();
    for (int c = 0; c < 64; c++) begin
      s_req[c] = '0;
      s_len[c] = '0;
    end
  endtask

  task automatic t_powerup();
    @(negedge clk);
    check(gnt == '0, "R1 grant at power-up", int'(gnt), 0);
    check(ovf == 1'b0, "R1 overflow at power-up", int'(ovf), 0);
  endtask

  task automatic t_single();
    clear_stim();
    s_req[0] = 4'b1000; s_len[0] = 16'h4000;
    build_expect(1, 99);
    run_case("R2 single request", 1, 99);
    check(a_str[0] == 0 && a_str[1] == 8, "R7 first grant latency", a_str[1], 8);
  endtask

  task automatic t_held();
    clear_stim();
    for (int c = 0; c < 3; c++) begin
      s_req[c] = 4'b0010; s_len[c] = 16'h0020;
    end
    run_case("R2 held line gives three grants", 3, 99);
  endtask

  task automatic t_order();
    clear_stim();
    s_req[0] = 4'b0100; s_len[0] = 16'h0300;
    s_req[1] = 4'b0001; s_len[1] = 16'h0002;
    s_req[2] = 4'b0010; s_len[2] = 16'h0010;
    run_case("R3 arrival order across cycles", 3, 99);
  endtask

  task automatic t_tie();
    clear_stim();
    s_req[0] = 4'b1011; s_len[0] = 16'h2031;
    run_case("R4 same-cycle ascending port", 1, 99);
  endtask

  task automatic t_clamp();
    clear_stim();
    s_req[0] = 4'b0011; s_len[0] = 16'h00F0;
    s_req[1] = 4'b1100; s_len[1] = 16'hA100;
    run_case("R5 length clamp 0/15/1/10", 2, 99);
  endtask

  task automatic t_rerequest();
    clear_stim();
    s_req[0] = 4'b0001; s_len[0] = 16'h0005;
    s_req[3] = 4'b0001; s_len[3] = 16'h0002;
    s_req[4] = 4'b0100; s_len[4] = 16'h0100;
    run_case("R9 request during own grant", 5, 99);
    check(ovf == 1'b0, "R8 no overflow below depth", int'(ovf), 0);
  endtask

  task automatic t_overflow();
    clear_stim();
    for (int c = 0; c < 5; c++) begin
      s_req[c] = 4'b1111; s_len[c] = 16'hAAAA;
    end
    // 16 before the fifth cycle's edge with one popped: 17 accepted
    run_case("R8 full queue drops highest ports", 5, 17);
    check(ovf == 1'b1, "R8 overflow flag set", int'(ovf), 1);
    repeat (4) @(negedge clk);
    check(ovf == 1'b1, "R8 overflow flag sticky", int'(ovf), 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    t_powerup();
    t_single();
    t_held();
    t_order();
    t_tie();
    t_clamp();
    t_rerequest();
    t_overflow();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule